// File: doc/BRIEF.md
# Branch trace port encoder

This block turns per-cycle events from a processor core into a real-time trace stream. The stream has two 4-bit lanes that are updated on every clock. A status lane gives a code for what the core did in that cycle. A data lane carries the target address of computed branches, one nibble per cycle.

A taken branch is reported on the status lane. When the branch target was computed at run time (a return, a register-indirect or indexed jump or call, or an exception vector), the target is also queued. A byte-count marker is then placed on the status lane, and the data lane streams 2, 3 or 4 bytes of the target, least significant nibble first. The byte count comes from a configuration field.

Stopped and halted states are shown as steady codes for as long as each state lasts. Up to two targets can wait behind the one being streamed. A further target is dropped, and this is recorded in a sticky flag.

Top module: `branch_trace_enc`

## Requirements
- R1: While rst_ni is low, trc_status_o, trc_data_o and trc_ovf_o are all 0, and no queued or partly streamed target appears after reset is released.
- R2: A taken branch sampled in run mode makes trc_status_o show 0x5 after that clock edge. A taken branch that is not computed produces no marker and no data.
- R3: For a computed branch, the status lane shows a marker in the cycle after the 0x5, if that cycle is free. The marker is 0x9 for byte-select 0 (2 bytes), 0xA for 1 (3 bytes) and 0xB for 2 or 3 (4 bytes). The byte-select is sampled with the branch.
- R4: The data lane starts in the cycle after the marker. It shows 4, 6 or 8 nibbles of the target on consecutive cycles, starting with bits [3:0] and moving up by 4 bits each cycle. Otherwise it shows 0x0.
- R5: In run mode with no event, the status lane shows 0x0. An instruction completion alone shows 0x1.
- R6: A stop request gives status 0xE. The code stays every cycle until a wake-up, and branch and completion inputs are ignored during that time.
- R7: A halt request gives status 0xF from any mode, and it wins over a stop request. The code stays until a wake-up (restart) or reset, and stop requests are ignored during that time.
- R8: A computed branch that arrives while another target is streaming is queued (2 entries). Targets are streamed in arrival order, each with its own marker, and a marker is issued only after the data lane has finished the previous target.
- R9: A computed branch that arrives while both queue entries are full is dropped, and trc_ovf_o goes to 1 and stays 1 until reset.
- R10: A branch report takes the status lane before a waiting marker, and the marker moves to the next free cycle.
- R11: In the cycle after a wake-up from stopped or halted, the status lane shows 0x0, and normal reporting resumes after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_done_i | input | 1 | An instruction completed this cycle |
| br_taken_i | input | 1 | A branch was taken this cycle |
| br_computed_i | input | 1 | The taken branch uses a computed target |
| br_target_i | input | 32 | Branch target address |
| stop_req_i | input | 1 | Core enters stopped mode |
| halt_req_i | input | 1 | Core enters halted mode |
| wake_i | input | 1 | Interrupt or restart that ends stopped or halted mode |
| addr_bytes_sel_i | input | 2 | Target bytes shown: 0=2, 1=3, 2 or 3=4 |
| trc_status_o | output | 4 | Trace status lane |
| trc_data_o | output | 4 | Trace data lane (address nibbles) |
| trc_ovf_o | output | 1 | Sticky flag: a target was dropped |

## Verification
The hardest state to reach is a full queue while the serializer is busy. A pop needs a cycle with no branch, so three computed branches are sent on back-to-back cycles. The first two fill the queue, and the third is dropped while no marker is issued. The bench then checks that both kept targets come out in order, each with its own marker and a gap between them, and that nothing is streamed for the dropped one. Marker deferral is reached by sending a plain taken branch in the cycle right after a computed one. A queued-during-streaming case places a second branch in the middle of the nibble stream.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_STOP = 2'd1,
    MODE_HALT = 2'd2
  } mode_e;

  localparam logic [3:0] ST_IDLE   = 4'h0;
  localparam logic [3:0] ST_INSN   = 4'h1;
  localparam logic [3:0] ST_BRANCH = 4'h5;
  localparam logic [3:0] ST_MARK   = 4'h9;  // base; +1 per extra byte
  localparam logic [3:0] ST_STOP   = 4'hE;
  localparam logic [3:0] ST_HALT   = 4'hF;

  // select 3 behaves as 4 bytes
  function automatic logic [1:0] clamp_sel(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction
endpackage

// File: rtl/trace_addr_fifo.sv
module trace_addr_fifo #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, push_ok, pop_ok;

  assign full    = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign ovf_o   = ovf_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (push_ok && wr_q == PTR_W'(g))        mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  a_r9_drop_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> ovf_q);
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/trace_nibble_ser.sv
module trace_nibble_ser #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned CNT_W = $clog2(ADDR_W / NIB_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  nib_cnt_i,
  output logic              idle_o,
  output logic [NIB_W-1:0]  data_o
);
  logic [ADDR_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NIB_W-1:0]  data_q;

  assign idle_o = (cnt_q == '0);
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (cnt_q != '0) begin
      data_q <= sh_q[NIB_W-1:0];
      sh_q   <= sh_q >> NIB_W;
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      data_q <= '0;
      if (start_i) begin
        sh_q  <= addr_i;
        cnt_q <= nib_cnt_i;
      end
    end
  end

  a_r8_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_q == '0));
  a_r4_marker_cycle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (data_q == '0));
endmodule

// File: rtl/trace_status_fsm.sv
module trace_status_fsm
  import trace_enc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       insn_done_i,
  input  logic       br_taken_i,
  input  logic       br_computed_i,
  input  logic       stop_req_i,
  input  logic       halt_req_i,
  input  logic       wake_i,
  input  logic       mark_go_i,
  input  logic [3:0] mark_code_i,
  output logic       mark_slot_o,
  output logic       push_o,
  output logic [3:0] status_o
);
  mode_e      mode_q;
  logic [3:0] st_q;
  logic       run_free;

  assign run_free    = (mode_q == MODE_RUN) && !halt_req_i && !stop_req_i;
  assign mark_slot_o = run_free && !br_taken_i;
  assign push_o      = run_free && br_taken_i && br_computed_i;
  assign status_o    = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      st_q   <= ST_IDLE;
    end else if (halt_req_i) begin
      mode_q <= MODE_HALT;
      st_q   <= ST_HALT;
    end else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (stop_req_i) begin
            mode_q <= MODE_STOP;
            st_q   <= ST_STOP;
          end else if (br_taken_i)  st_q <= ST_BRANCH;
          else if (mark_go_i)       st_q <= mark_code_i;
          else if (insn_done_i)     st_q <= ST_INSN;
          else                      st_q <= ST_IDLE;
        end
        MODE_STOP: begin
          if (wake_i) begin
            mode_q <= MODE_RUN;
            st_q   <= ST_IDLE;
          end else st_q <= ST_STOP;
        end
        MODE_HALT: begin
          if (wake_i) begin
            mode_q <= MODE_RUN;
            st_q   <= ST_IDLE;
          end else st_q <= ST_HALT;
        end
        default: begin
          mode_q <= MODE_RUN;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  a_r7_halt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_i |=> (st_q == ST_HALT));
  a_r6_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !halt_req_i && !wake_i) |=> (st_q == ST_STOP));
  a_r11_wake_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_RUN && wake_i && !halt_req_i) |=> (st_q == ST_IDLE));
  a_r2_branch_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && br_taken_i && !halt_req_i && !stop_req_i)
      |=> (st_q == ST_BRANCH));
endmodule

// File: rtl/branch_trace_enc.sv
module branch_trace_enc
  import trace_enc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_done_i,
  input  logic              br_taken_i,
  input  logic              br_computed_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              stop_req_i,
  input  logic              halt_req_i,
  input  logic              wake_i,
  input  logic [1:0]        addr_bytes_sel_i,
  output logic [3:0]        trc_status_o,
  output logic [3:0]        trc_data_o,
  output logic              trc_ovf_o
);
  localparam int unsigned NIB_W = 4;
  localparam int unsigned ENT_W = ADDR_W + 2;
  localparam int unsigned CNT_W = $clog2(ADDR_W / NIB_W + 1);

  logic              push, pop, empty, ser_idle, mark_slot;
  logic [ENT_W-1:0]  head;
  logic [1:0]        head_sel;
  logic [3:0]        mark_code;
  logic [CNT_W-1:0]  nib_cnt;

  assign head_sel  = head[ENT_W-1 -: 2];
  assign mark_code = ST_MARK + {2'b00, head_sel};
  assign nib_cnt   = CNT_W'({head_sel, 1'b0}) + CNT_W'(4);
  assign pop       = mark_slot && !empty && ser_idle;

  trace_status_fsm u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .insn_done_i   (insn_done_i),
    .br_taken_i    (br_taken_i),
    .br_computed_i (br_computed_i),
    .stop_req_i    (stop_req_i),
    .halt_req_i    (halt_req_i),
    .wake_i        (wake_i),
    .mark_go_i     (pop),
    .mark_code_i   (mark_code),
    .mark_slot_o   (mark_slot),
    .push_o        (push),
    .status_o      (trc_status_o)
  );

  trace_addr_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({clamp_sel(addr_bytes_sel_i), br_target_i}),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (empty),
    .ovf_o   (trc_ovf_o)
  );

  trace_nibble_ser #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (pop),
    .addr_i    (head[ADDR_W-1:0]),
    .nib_cnt_i (nib_cnt),
    .idle_o    (ser_idle),
    .data_o    (trc_data_o)
  );

  a_r3_marker_follows_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (trc_status_o >= 4'h9 && trc_status_o <= 4'hB));
  a_r10_no_marker_on_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |-> !pop);
endmodule

// File: tb/branch_trace_enc_tb.sv
module branch_trace_enc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        insn_done, br_taken, br_computed, stop_req, halt_req, wake;
  logic [31:0] br_target;
  logic [1:0]  sel;
  logic [3:0]  st, dat;
  logic        ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  branch_trace_enc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_done_i(insn_done), .br_taken_i(br_taken),
    .br_computed_i(br_computed), .br_target_i(br_target), .stop_req_i(stop_req),
    .halt_req_i(halt_req), .wake_i(wake), .addr_bytes_sel_i(sel),
    .trc_status_o(st), .trc_data_o(dat), .trc_ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    insn_done = 0; br_taken = 0; br_computed = 0; stop_req = 0;
    halt_req = 0; wake = 0; br_target = '0; sel = 2'd0;
  endtask

  // checks nn nibbles of a on the data lane with an idle status lane
  task automatic expect_nibbles(input string req, input logic [31:0] a, input int nn);
    for (int i = 0; i < nn; i++) begin
      step();
      chk({req, " nibble"}, dat, 4'(a >> (4 * i)));
      chk({req, " status during data"}, st, 4'h0);
    end
  endtask

  task automatic t_reset();
    quiet();
    step(); step();
    chk("R1 status in reset", st, 4'h0);
    chk("R1 data in reset", dat, 4'h0);
    chk("R1 ovf in reset", {3'b0, ovf}, 4'h0);
    rst_ni = 1'b1;
    step();
    chk("R5 idle status", st, 4'h0);
  endtask

  task automatic t_insn();
    insn_done = 1; step(); quiet();
    chk("R5 completion code", st, 4'h1);
    step();
    chk("R5 back to idle", st, 4'h0);
  endtask

  task automatic t_plain_branch();
    br_taken = 1; br_target = 32'hDEAD_BEEF; step(); quiet();
    chk("R2 branch code", st, 4'h5);
    step();
    chk("R2 no marker", st, 4'h0);
    chk("R2 no data", dat, 4'h0);
    step();
    chk("R2 still no data", dat, 4'h0);
  endtask

  task automatic t_computed(input string req, input logic [1:0] s, input logic [31:0] a,
                            input logic [3:0] mark, input int nn);
    br_taken = 1; br_computed = 1; br_target = a; sel = s; step(); quiet();
    sel = ~s;  // select must be sampled with the branch
    chk({req, " branch code"}, st, 4'h5);
    step();
    chk({req, " marker"}, st, mark);
    chk({req, " data quiet on marker"}, dat, 4'h0);
    expect_nibbles(req, a, nn);
    step();
    chk({req, " data ends"}, dat, 4'h0);
    sel = 0;
  endtask

  task automatic t_defer();
    br_taken = 1; br_computed = 1; br_target = 32'h0000_4E21; step(); quiet();
    chk("R10 first branch", st, 4'h5);
    br_taken = 1; step(); quiet();
    chk("R10 branch takes status", st, 4'h5);
    chk("R10 no data yet", dat, 4'h0);
    step();
    chk("R10 deferred marker", st, 4'h9);
    expect_nibbles("R10", 32'h0000_4E21, 4);
  endtask

  task automatic t_queue_mid();
    br_taken = 1; br_computed = 1; br_target = 32'h0000_8765; step(); quiet();
    chk("R8 first branch", st, 4'h5);
    step();
    chk("R8 first marker", st, 4'h9);
    step(); chk("R8 A n0", dat, 4'h5);
    br_taken = 1; br_computed = 1; br_target = 32'h00C0_FFEE; sel = 2'd1; step(); quiet();
    chk("R8 branch during data", st, 4'h5);
    chk("R8 A n1", dat, 4'h6);
    step(); chk("R8 A n2", dat, 4'h7); chk("R8 no early marker", st, 4'h0);
    step(); chk("R8 A n3", dat, 4'h8); chk("R8 no early marker", st, 4'h0);
    step();
    chk("R8 second marker", st, 4'hA);
    chk("R8 gap before B", dat, 4'h0);
    expect_nibbles("R8 B", 32'h00C0_FFEE, 6);
    step();
    chk("R8 done", dat, 4'h0);
  endtask

  task automatic t_overflow();
    br_taken = 1; br_computed = 1; br_target = 32'h0000_1234; step();
    chk("R9 no ovf after one", {3'b0, ovf}, 4'h0);
    br_target = 32'h0000_ABCD; step();
    chk("R9 no ovf at full", {3'b0, ovf}, 4'h0);
    br_target = 32'h0000_5A5A; step(); quiet();
    chk("R9 ovf set on drop", {3'b0, ovf}, 4'h1);
    chk("R9 third branch reported", st, 4'h5);
    step(); chk("R8 marker A", st, 4'h9);
    expect_nibbles("R8 A", 32'h0000_1234, 4);
    step(); chk("R8 marker B", st, 4'h9); chk("R8 gap", dat, 4'h0);
    expect_nibbles("R8 B", 32'h0000_ABCD, 4);
    step(); chk("R9 dropped has no marker", st, 4'h0); chk("R9 dropped no data", dat, 4'h0);
    step(); chk("R9 dropped no data later", dat, 4'h0);
    chk("R9 ovf sticky", {3'b0, ovf}, 4'h1);
  endtask

  task automatic t_stop();
    stop_req = 1; step(); quiet();
    chk("R6 stop code", st, 4'hE);
    step(); chk("R6 stop held", st, 4'hE);
    br_taken = 1; br_computed = 1; br_target = 32'h0000_FFFF; insn_done = 1; step(); quiet();
    chk("R6 branch ignored", st, 4'hE);
    step(); chk("R6 stop held after", st, 4'hE);
    wake = 1; step(); quiet();
    chk("R11 wake idle", st, 4'h0);
    step(); chk("R6 no ghost marker", st, 4'h0); chk("R6 no ghost data", dat, 4'h0);
    insn_done = 1; step(); quiet();
    chk("R11 normal after wake", st, 4'h1);
  endtask

  task automatic t_halt();
    halt_req = 1; stop_req = 1; step(); quiet();
    chk("R7 halt beats stop", st, 4'hF);
    stop_req = 1; step(); quiet();
    chk("R7 stop ignored in halt", st, 4'hF);
    step(); chk("R7 halt held", st, 4'hF);
    wake = 1; step(); quiet();
    chk("R11 restart idle", st, 4'h0);
    stop_req = 1; step(); quiet();
    chk("R6 stop again", st, 4'hE);
    halt_req = 1; step(); quiet();
    chk("R7 halt from stop", st, 4'hF);
    wake = 1; step(); quiet();
    chk("R11 restart from halt", st, 4'h0);
  endtask

  task automatic t_reset_mid();
    br_taken = 1; br_computed = 1; br_target = 32'h0000_7777; step(); quiet();
    br_taken = 1; br_computed = 1; br_target = 32'h0000_3333; step(); quiet();
    step(); chk("R1 mid marker", st, 4'h9);
    step(); chk("R1 mid nibble", dat, 4'h7);
    rst_ni = 1'b0; #1;
    chk("R1 async status", st, 4'h0);
    chk("R1 async data", dat, 4'h0);
    chk("R1 ovf cleared", {3'b0, ovf}, 4'h0);
    step(); rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R1 no leftover data", dat, 4'h0);
      chk("R1 no leftover marker", st, 4'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_insn();
    t_plain_branch();
    t_computed("R3 R4 two bytes", 2'd0, 32'h89AB_CDEF, 4'h9, 4);
    t_computed("R3 R4 three bytes", 2'd1, 32'h1357_9BDF, 4'hA, 6);
    t_computed("R3 R4 four bytes", 2'd2, 32'hF0E1_D2C3, 4'hB, 8);
    t_computed("R3 R4 select three", 2'd3, 32'h2468_ACE0, 4'hB, 8);
    t_defer();
    t_queue_mid();
    t_overflow();
    t_stop();
    t_halt();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule